// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block merges a group of device interrupt lines into one level-sensitive request toward a system interrupt controller. Devices raise requests by pulsing a bit vector on a post input, and withdraw them with a bit vector on a clear input. Each set bit in a post vector latches into a pending register. An enable-high mask, loaded through a small byte-wide register port, chooses which pending lines may drive the output.

The output is a sticky level, not a plain OR of pending and enabled bits. It rises when a post or an enable-mask write leaves some enabled line pending. It falls only on a clear strobe that leaves no enabled line pending. So software can write a mask that disables every pending line, and the request stays up until a device clears something. A second, shadow mask can be written and read back through the same port, but it has no path to the output.

Top module: `maskIrqAgg`

## Requirements
- R1: Reset (synchronous, active-high `rst`) clears the pending register, the enable mask, the shadow mask and `irqOut`.
- R2: A cycle with a nonzero `postVec` ORs that vector into the pending register at the next rising clock edge.
- R3: A nonzero `clearVec` removes its bits from pending at the next edge. When post and clear arrive in the same cycle, the clear is applied after the post, so a bit that is both posted and cleared ends up not pending.
- R4: `irqOut` is registered. It goes high one edge after a cycle in which a nonzero post or an enable-mask write leaves (pending AND enable) nonzero. When there is neither a post nor an enable write, a low `irqOut` stays low.
- R5: While `irqOut` is high and `clearVec` is zero, `irqOut` stays high. This holds even when an enable write disables every pending line.
- R6: A nonzero `clearVec` that leaves (pending AND enable) zero, with post and enable write applied first, drives `irqOut` low at the next edge. A clear that leaves some enabled line pending keeps `irqOut` high.
- R7: The shadow mask is writable and readable but never raises or holds `irqOut`.
- R8: Register port map, with bit i of each register belonging to line i and the enable mask enable-high (1 lets the line through): address 0 is the enable mask, read/write; address 1 is the shadow mask, read/write; address 2 is the pending register, read-only; address 3 reads zero. Writes to addresses 2 and 3 are ignored. Read data is combinational from the current register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| postVec | input | NUM_LINES | Bit-vector strobe that sets pending bits |
| clearVec | input | NUM_LINES | Bit-vector strobe that clears pending bits |
| regWrEn | input | 1 | Register port write strobe |
| regAddr | input | 2 | Register port address |
| regWrData | input | NUM_LINES | Register port write data |
| regRdData | output | NUM_LINES | Register port read data for `regAddr` |
| irqOut | output | 1 | Sticky aggregated interrupt request |

## Verification
The bench builds the block with NUM_LINES = 8, so every line fits in one byte and the shadow mask can be loaded with all ones without any effect. This width also allows posted, cleared and enabled sets that are disjoint, overlapping or identical. That reaches the same-cycle post/clear ordering, a clear that hits a line that is not pending, and the sticky hold after a mask write that disables every line.

// File: rtl/maskIrqPkg.sv
package maskIrqPkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SHADOW  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PENDING = 2'd2;

  // control -> datapath
  typedef struct packed {
    logic enWr;
    logic shadowWr;
  } aggCtrlT;

  // datapath -> control
  typedef struct packed {
    logic postSeen;
    logic clearSeen;
    logic liveAfterPost;
    logic liveAfterClear;
  } aggStatusT;

endpackage

// File: rtl/aggDatapath.sv
module aggDatapath
  import maskIrqPkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  aggCtrlT              ctl,
  input  logic [NUM_LINES-1:0] postVec,
  input  logic [NUM_LINES-1:0] clearVec,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output aggStatusT            status
);

  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] pendPost;
  logic [NUM_LINES-1:0] pendNext;
  logic [NUM_LINES-1:0] enQ;
  logic [NUM_LINES-1:0] enNext;
  logic [NUM_LINES-1:0] shadowQ;

  // per-line pending cell: post first, then clear
  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    assign pendPost[i] = pendQ[i] | postVec[i];
    assign pendNext[i] = pendPost[i] & ~clearVec[i];

    always_ff @(posedge clk) begin
      if (rst) pendQ[i] <= 1'b0;
      else     pendQ[i] <= pendNext[i];
    end
  end

  assign enNext = ctl.enWr ? regWrData : enQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ     <= '0;
      shadowQ <= '0;
    end else begin
      enQ <= enNext;
      if (ctl.shadowWr) shadowQ <= regWrData;
    end
  end

  always_comb begin
    status.postSeen       = |postVec;
    status.clearSeen      = |clearVec;
    status.liveAfterPost  = |(pendPost & enNext);
    status.liveAfterClear = |(pendNext & enNext);
  end

  always_comb begin
    unique case (regAddr)
      ADDR_ENABLE:  regRdData = enQ;
      ADDR_SHADOW:  regRdData = shadowQ;
      ADDR_PENDING: regRdData = pendQ;
      default:      regRdData = '0;
    endcase
  end

endmodule

// File: rtl/aggControl.sv
module aggControl
  import maskIrqPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  aggStatusT         status,
  output aggCtrlT           ctl,
  output logic              irqOut
);

  logic raiseReq;
  logic dropReq;
  logic irqQ;

  always_comb begin
    ctl.enWr     = regWrEn && (regAddr == ADDR_ENABLE);
    ctl.shadowWr = regWrEn && (regAddr == ADDR_SHADOW);
  end

  // raise after post / enable write, drop only on a clear that empties
  assign raiseReq = (status.postSeen || ctl.enWr) && status.liveAfterPost;
  assign dropReq  = status.clearSeen && !status.liveAfterClear;

  always_ff @(posedge clk) begin
    if (rst)           irqQ <= 1'b0;
    else if (dropReq)  irqQ <= 1'b0;
    else if (raiseReq) irqQ <= 1'b1;
  end

  assign irqOut = irqQ;

endmodule

// File: rtl/maskIrqAgg.sv
module maskIrqAgg
  import maskIrqPkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] postVec,
  input  logic [NUM_LINES-1:0] clearVec,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 irqOut
);

  aggCtrlT   ctlStrobes;
  aggStatusT dpStatus;

  aggControl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .status  (dpStatus),
    .ctl     (ctlStrobes),
    .irqOut  (irqOut)
  );

  aggDatapath #(.NUM_LINES(NUM_LINES)) uData (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctlStrobes),
    .postVec   (postVec),
    .clearVec  (clearVec),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .status    (dpStatus)
  );

endmodule

// File: rtl/aggChecker.sv
module aggChecker
  import maskIrqPkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] postVec,
  input logic [NUM_LINES-1:0] clearVec,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [NUM_LINES-1:0] regRdData,
  input logic                 irqOut,
  input aggStatusT            dpStatus
);

  logic enWrite;
  assign enWrite = regWrEn && (regAddr == ADDR_ENABLE);

  AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irqOut && !(|clearVec)) |=> irqOut); // R5

  AST_NO_SPURIOUS_RISE: assert property (@(posedge clk) disable iff (rst)
    (!irqOut && !(|postVec) && !enWrite) |=> !irqOut); // R4 R7

  AST_DROP_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    ((|clearVec) && !dpStatus.liveAfterClear) |=> !irqOut); // R6

  AST_RAISE_ON_LIVE: assert property (@(posedge clk) disable iff (rst)
    (((|postVec) || enWrite) && dpStatus.liveAfterClear) |=> irqOut); // R4

  AST_KEEP_ON_LIVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irqOut && dpStatus.liveAfterClear) |=> irqOut); // R6

  AST_SPARE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd3) |-> (regRdData == '0)); // R8

endmodule

bind maskIrqAgg aggChecker #(.NUM_LINES(NUM_LINES)) chk (
  .clk       (clk),
  .rst       (rst),
  .postVec   (postVec),
  .clearVec  (clearVec),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .dpStatus  (dpStatus)
);

// File: tb/tb_maskIrqAgg.sv
module tb_maskIrqAgg;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] postVec;
  logic [N-1:0] clearVec;
  logic         regWrEn;
  logic [1:0]   regAddr;
  logic [N-1:0] regWrData;
  logic [N-1:0] regRdData;
  logic         irqOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #4 clk = ~clk; // 125 MHz

  maskIrqAgg #(.NUM_LINES(N)) dut (
    .clk(clk), .rst(rst), .postVec(postVec), .clearVec(clearVec),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [7:0] post;
    logic [7:0] clr;
    logic       wr;
    logic [1:0] addr;
    logic [7:0] data;
    logic       expIrq;
    logic [7:0] expPend;
  } rowT;

  // addr 0 enable, 1 shadow, 2 pending
  localparam int NROWS = 15;
  localparam rowT ROWS [NROWS] = '{
    '{8'h05, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 8'h05}, // R2 post masked
    '{8'h00, 8'h00, 1'b1, 2'd1, 8'hFF, 1'b0, 8'h05}, // R7 shadow all ones
    '{8'h00, 8'h00, 1'b1, 2'd0, 8'h04, 1'b1, 8'h05}, // R4 enable write raises
    '{8'h00, 8'h00, 1'b1, 2'd0, 8'h00, 1'b1, 8'h05}, // R5 disable all, sticky
    '{8'h00, 8'h01, 1'b0, 2'd0, 8'h00, 1'b0, 8'h04}, // R6 clear drops
    '{8'h00, 8'h00, 1'b1, 2'd0, 8'h10, 1'b0, 8'h04}, // R4 enable non-pending
    '{8'h10, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 8'h14}, // R4 post raises
    '{8'h00, 8'h04, 1'b0, 2'd0, 8'h00, 1'b1, 8'h10}, // R6 clear keeps
    '{8'h20, 8'h10, 1'b0, 2'd0, 8'h00, 1'b0, 8'h20}, // R3 post+clear drops
    '{8'h10, 8'h10, 1'b0, 2'd0, 8'h00, 1'b0, 8'h20}, // R3 same bit cleared
    '{8'h00, 8'h00, 1'b1, 2'd0, 8'h20, 1'b1, 8'h20}, // R4 enable raises
    '{8'h00, 8'h00, 1'b1, 2'd2, 8'hFF, 1'b1, 8'h20}, // R8 pending write ignored
    '{8'h00, 8'h80, 1'b0, 2'd0, 8'h00, 1'b1, 8'h20}, // R6 clear idle line
    '{8'h00, 8'h20, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00}, // R6 last clear drops
    '{8'h80, 8'h00, 1'b1, 2'd0, 8'h80, 1'b1, 8'h80}  // R4 post+enable same cycle
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic step(input logic [7:0] p, input logic [7:0] c,
                      input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    postVec = p; clearVec = c; regWrEn = w; regAddr = a; regWrData = d;
    @(posedge clk);
    #1;
    postVec = '0; clearVec = '0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; postVec = '0; clearVec = '0; regWrEn = 1'b0;
    regAddr = '0; regWrData = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    readReg(2'd0, v); check("R1 enable", v, 8'h00);
    readReg(2'd1, v); check("R1 shadow", v, 8'h00);
    readReg(2'd2, v); check("R1 pending", v, 8'h00);

    for (int i = 0; i < NROWS; i++) begin
      step(ROWS[i].post, ROWS[i].clr, ROWS[i].wr, ROWS[i].addr, ROWS[i].data);
      check($sformatf("row%0d irq R4/R5/R6", i), {7'd0, irqOut}, {7'd0, ROWS[i].expIrq});
      readReg(2'd2, v);
      check($sformatf("row%0d pending R2/R3", i), v, ROWS[i].expPend);
    end

    // R7 shadow readback; R8 register map
    readReg(2'd1, v); check("R7 shadow readback", v, 8'hFF);
    readReg(2'd0, v); check("R8 enable readback", v, 8'h80);
    readReg(2'd3, v); check("R8 spare reads zero", v, 8'h00);
    step(8'h00, 8'h00, 1'b1, 2'd3, 8'hAA);
    readReg(2'd3, v); check("R8 spare write ignored", v, 8'h00);
    readReg(2'd0, v); check("R8 enable untouched", v, 8'h80);

    // R7 shadow write while irq low and a masked line pending
    step(8'h00, 8'h80, 1'b0, 2'd0, 8'h00);
    check("R6 drop", {7'd0, irqOut}, 8'h00);
    step(8'h02, 8'h00, 1'b0, 2'd0, 8'h00);
    step(8'h00, 8'h00, 1'b1, 2'd1, 8'h02);
    check("R7 shadow no raise", {7'd0, irqOut}, 8'h00);

    // R1 reset mid-operation
    step(8'h00, 8'h00, 1'b1, 2'd0, 8'h02);
    check("R4 pre-reset irq", {7'd0, irqOut}, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    check("R1 irq after reset", {7'd0, irqOut}, 8'h00);
    readReg(2'd0, v); check("R1 enable after reset", v, 8'h00);
    readReg(2'd1, v); check("R1 shadow after reset", v, 8'h00);
    readReg(2'd2, v); check("R1 pending after reset", v, 8'h00);

    finish();
  end

endmodule